// File: doc/BRIEF.md
# Comma Word Aligner

This block sits behind a clock and data recovery stage. It takes one recovered line bit per clock and returns the stream as 10-bit words, one word every ten clocks, with a one-cycle valid strobe. It keeps the last twenty bits and, on each word tick, tests the ten candidate word starts for the seven-bit comma prefix that 8b/10b control symbols K28.1, K28.5 and K28.7 carry in both running disparities. When the word boundary has to move, the comma word goes out at once at the new start and sets a flag. Every later word follows on contiguously from that start.

An alignment-enable input decides whether the boundary may follow a comma that appears at a new start. Commas that already sit on the boundary always raise the flag, whatever the enable is doing. The block also keeps a one-bit memory that records whether alignment has ever happened. With the enable low, this memory allows exactly one alignment, to the first comma, if none has happened yet. Comma search only runs while the receiver reports lock.

Top module: `wa_word_aligner`

## Requirements
- R1: While reset is asserted and until the first word tick, `word_vld_o` and `comma_o` are 0 and `word_o` is all zeros.
- R2: `word_vld_o` pulses for one cycle every 10 clocks. Word bit 0 is the earliest bit received, and consecutive words without realignment cover consecutive bits of the stream.
- R3: A comma is a word whose bits 0..6, in receive order, are 0,0,1,1,1,1,1 or 1,1,0,0,0,0,0. This covers K28.1, K28.5 and K28.7 in either disparity, for example K28.5 = 10'h17C or 10'h283 with bit 0 as the LSB.
- R4: With the enable high and no comma on the current boundary, a comma found at another start is output as the current word with `comma_o` = 1. Later words continue from that start.
- R5: `comma_o` is 1 on any word that holds a comma at the current boundary, whether the enable is high or low.
- R6: With the enable low, once alignment has happened, a comma at another start is ignored: `comma_o` stays 0 and the boundary does not move.
- R7: With the enable low and no alignment since reset, the block aligns to the first comma found, with `comma_o` = 1, and to no later one.
- R8: While `lock_i` is low, no comma is detected, so `comma_o` stays 0 and the boundary does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Receiver lock; enables comma search |
| bit_i | input | 1 | Recovered serial bit |
| align_en_i | input | 1 | Allows realignment to any comma at a new start |
| word_o | output | SYM_W | Aligned word, bit 0 received first |
| word_vld_o | output | 1 | One-cycle strobe per output word |
| comma_o | output | 1 | Current word holds a comma on the boundary |

## Verification
The assertions assume that a new bit is presented on every clock after reset, so the word tick falls exactly every ten edges. They also assume that `lock_i` and `align_en_i` only matter at tick edges, where they are sampled. The bench meets both assumptions with a driver that feeds a bit at every falling edge from the moment reset is released, padding with zeros once the stimulus runs out. It changes lock and enable only together with the bits they belong to. Odd-length pads move the commas onto new starts, so the enable-low and enable-high cases are each reached from a known alignment history.

// File: rtl/wa_pkg.sv
package wa_pkg;
   typedef enum logic [1:0] {
      WA_IDLE,
      WA_KEEP,
      WA_MOVE
   } wa_act_e;

   localparam int unsigned WA_SYM_W  = 10;
   localparam int unsigned WA_MARK_W = 7;
   // prefix bits written MSB..LSB; LSB is the first received bit
   localparam logic [WA_MARK_W-1:0] WA_MARK_P = 7'b1111100;
   localparam logic [WA_MARK_W-1:0] WA_MARK_N = 7'b0000011;
endpackage

// File: rtl/wa_comma_match.sv
module wa_comma_match #(
   parameter int unsigned           SYM_W    = wa_pkg::WA_SYM_W,
   parameter int unsigned           MARK_W   = wa_pkg::WA_MARK_W,
   parameter logic [MARK_W-1:0]     MARK_P   = wa_pkg::WA_MARK_P,
   parameter logic [MARK_W-1:0]     MARK_N   = wa_pkg::WA_MARK_N,
   parameter bit                    BOTH_POL = 1'b1
) (
   input  logic [SYM_W-1:0] win_i,
   input  logic             en_i,
   output logic             hit_o
);
   initial begin
      mark_fits_chk: assert (MARK_W <= SYM_W && MARK_W > 0)
         else $error("comma prefix wider than symbol");
   end

   logic [MARK_W-1:0] head;
   assign head = win_i[MARK_W-1:0];

   generate
      if (BOTH_POL) begin : g_both
         assign hit_o = en_i && ((head == MARK_P) || (head == MARK_N));
      end else begin : g_one
         assign hit_o = en_i && (head == MARK_P);
      end
   endgenerate
endmodule

// File: rtl/wa_offset_pick.sv
module wa_offset_pick #(
   parameter int unsigned N = 10
) (
   input  logic [N-1:0]         req_i,
   output logic                 any_o,
   output logic [$clog2(N)-1:0] idx_o
);
   localparam int unsigned IW = $clog2(N);

   initial begin
      pick_size_chk: assert (N >= 2) else $error("need at least two offsets");
   end

   // lowest offset = oldest candidate wins
   always_comb begin
      any_o = |req_i;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IW'(i);
      end
   end
endmodule

// File: rtl/wa_word_aligner.sv
module wa_word_aligner #(
   parameter int unsigned       SYM_W  = wa_pkg::WA_SYM_W,
   parameter int unsigned       MARK_W = wa_pkg::WA_MARK_W,
   parameter logic [MARK_W-1:0] MARK_P = wa_pkg::WA_MARK_P,
   parameter logic [MARK_W-1:0] MARK_N = wa_pkg::WA_MARK_N
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_i,
   input  logic             bit_i,
   input  logic             align_en_i,
   output logic [SYM_W-1:0] word_o,
   output logic             word_vld_o,
   output logic             comma_o
);
   import wa_pkg::*;

   localparam int unsigned HIST_W = 2 * SYM_W;
   localparam int unsigned OFF_W  = $clog2(SYM_W);
   localparam int unsigned CNT_W  = $clog2(SYM_W);

   initial begin
      sym_size_chk: assert (SYM_W >= 2 && SYM_W >= MARK_W)
         else $error("symbol width too small");
   end

   logic [HIST_W-1:0] hist_q, hist_d;
   logic [CNT_W-1:0]  cnt_q;
   logic              tick;
   logic [OFF_W-1:0]  sel_q, sel_d, pick_idx;
   logic              ever_q, pick_any;
   logic [SYM_W-1:0]  hits;
   logic [SYM_W-1:0]  win [SYM_W];
   wa_act_e           act;

   // newest bit enters at the top; bit 0 of any window is its oldest bit
   assign hist_d = {bit_i, hist_q[HIST_W-1:1]};
   assign tick   = (cnt_q == CNT_W'(SYM_W - 1));

   generate
      for (genvar k = 0; k < SYM_W; k++) begin : g_off
         assign win[k] = hist_d[k +: SYM_W];
         wa_comma_match #(
            .SYM_W(SYM_W), .MARK_W(MARK_W),
            .MARK_P(MARK_P), .MARK_N(MARK_N), .BOTH_POL(1'b1)
         ) u_match (
            .win_i(win[k]),
            .en_i (lock_i),
            .hit_o(hits[k])
         );
      end
   endgenerate

   wa_offset_pick #(.N(SYM_W)) u_pick (
      .req_i(hits),
      .any_o(pick_any),
      .idx_o(pick_idx)
   );

   always_comb begin
      act = WA_IDLE;
      if (hits[sel_q])                               act = WA_KEEP;
      else if (pick_any && (align_en_i || !ever_q))  act = WA_MOVE;
      sel_d = (act == WA_MOVE) ? pick_idx : sel_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q     <= '0;
         cnt_q      <= '0;
         sel_q      <= '0;
         ever_q     <= 1'b0;
         word_o     <= '0;
         word_vld_o <= 1'b0;
         comma_o    <= 1'b0;
      end else begin
         hist_q     <= hist_d;
         cnt_q      <= tick ? '0 : cnt_q + 1'b1;
         word_vld_o <= tick;
         comma_o    <= tick && (act != WA_IDLE);
         if (tick) begin
            word_o <= win[sel_d];
            sel_q  <= sel_d;
            if (act != WA_IDLE) ever_q <= 1'b1;
         end
      end
   end

   // R2
   word_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |=> !word_vld_o);
   // R3
   comma_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      comma_o |-> (word_o[MARK_W-1:0] == MARK_P || word_o[MARK_W-1:0] == MARK_N));
   // R5
   comma_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      comma_o |-> word_vld_o);
   // R7
   comma_sets_memory_chk: assert property (@(posedge clk) disable iff (!rst_n)
      comma_o |-> ever_q);
   // R6
   frozen_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ever_q && !align_en_i) |=> $stable(sel_q));
   // R4
   follow_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && align_en_i && pick_any && !hits[sel_q]) |=> (comma_o && sel_q == $past(pick_idx)));
   // R8
   no_lock_no_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld_o && !$past(lock_i)) |-> !comma_o);
endmodule

// File: tb/tb_wa_word_aligner.sv
module tb_wa_word_aligner;
   localparam int W = 10;

   typedef struct { logic b; logic lk; logic en; string tag; } stim_t;
   typedef struct { logic [W-1:0] w; logic c; string tag; } exp_t;

   logic clk = 1'b0, rst_n = 1'b0, lock_i = 1'b0, bit_i = 1'b0, align_en_i = 1'b0;
   logic [W-1:0] word_o;
   logic word_vld_o, comma_o;

   stim_t stim[$];
   exp_t  expq[$];
   logic  bits[$];
   int    checks = 0, fails = 0;
   int    m_sel = 0;
   bit    m_ever = 0;
   bit    done = 0;

   localparam logic [W-1:0] K5N = 10'h17C, K5P = 10'h283;
   localparam logic [W-1:0] K1N = 10'b1001111100, K1P = 10'b0110000011;
   localparam logic [W-1:0] K7N = 10'b0001111100, K7P = 10'b1110000011;
   localparam logic [W-1:0] FILL = 10'b0101010101;

   always #4 clk = ~clk;

   wa_word_aligner dut (
      .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .bit_i(bit_i),
      .align_en_i(align_en_i), .word_o(word_o), .word_vld_o(word_vld_o),
      .comma_o(comma_o)
   );

   task automatic put_sym(input logic [W-1:0] s, input logic lk, input logic en, input string t);
      for (int i = 0; i < W; i++) stim.push_back('{s[i], lk, en, t});
   endtask

   task automatic put_pad(input int n, input logic lk, input logic en, input string t);
      for (int i = 0; i < n; i++) stim.push_back('{logic'(i % 2), lk, en, t});
   endtask

   function automatic logic getb(input int i);
      return (i < 0) ? 1'b0 : bits[i];
   endfunction

   // comma prefix per R3: receive order 0011111 or 1100000
   function automatic bit mark_at(input int s);
      bit a = 1, b = 1;
      for (int j = 0; j < 7; j++) begin
         logic want = (j >= 2);
         if (getb(s + j) !== want)  a = 0;
         if (getb(s + j) !== !want) b = 0;
      end
      return a || b;
   endfunction

   // reference: absolute bit positions, one word every 10 bits
   task automatic model_tick(input logic lk, input logic en, input string t);
      int base = bits.size() - 20;
      int first = -1;
      bit on_sel;
      exp_t e;
      on_sel = lk && mark_at(base + m_sel);
      for (int k = W - 1; k >= 0; k--) if (lk && mark_at(base + k)) first = k;
      e.c = 1'b0;
      if (on_sel) e.c = 1'b1;
      else if (first >= 0 && (en || !m_ever)) begin
         m_sel = first;
         e.c = 1'b1;
      end
      if (e.c) m_ever = 1;
      for (int j = 0; j < W; j++) e.w[j] = getb(base + m_sel + j);
      e.tag = t;
      expq.push_back(e);
   endtask

   task automatic drive_one(input stim_t s);
      bit_i = s.b; lock_i = s.lk; align_en_i = s.en;
      bits.push_back(s.b);
      if (bits.size() % W == 0) model_tick(s.lk, s.en, s.tag);
   endtask

   // monitor
   int gap = 0;
   bit seen = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         gap++;
         if (word_vld_o) begin
            exp_t e;
            if (seen && gap != W) begin
               fails++;
               $display("FAIL R2 word spacing actual=%0d expected=%0d", gap, W);
            end
            seen = 1; gap = 0;
            checks++;
            if (expq.size() == 0) begin
               fails++;
               $display("FAIL R2 unexpected word actual=%h expected=none", word_o);
            end else begin
               e = expq.pop_front();
               if (word_o !== e.w || comma_o !== e.c) begin
                  fails++;
                  $display("FAIL %s word actual=%h/%b expected=%h/%b", e.tag, word_o, comma_o, e.w, e.c);
               end
            end
         end else if (comma_o !== 1'b0) begin
            checks++; fails++;
            $display("FAIL R5 flag without word actual=%b expected=0", comma_o);
         end
      end
   end

   initial begin
      // R8: lock low, misaligned comma must not be used
      put_sym(FILL, 0, 1, "R8"); put_sym(FILL, 0, 1, "R8"); put_pad(3, 0, 1, "R8");
      put_sym(K5N, 0, 1, "R8"); put_sym(FILL, 0, 1, "R8"); put_sym(FILL, 0, 1, "R8");
      put_sym(FILL, 0, 1, "R8");
      // R7: enable low, never aligned -> first comma aligns
      put_sym(FILL, 1, 0, "R7"); put_sym(K5P, 1, 0, "R7");
      put_sym(10'h2B3, 1, 0, "R7"); put_sym(FILL, 1, 0, "R7");
      // R6: enable low, already aligned -> shifted comma ignored
      put_pad(4, 1, 0, "R6"); put_sym(K5N, 1, 0, "R6");
      put_sym(FILL, 1, 0, "R6"); put_sym(FILL, 1, 0, "R6");
      // R5: back on the old boundary, enable still low
      put_pad(6, 1, 0, "R5"); put_sym(K1N, 1, 0, "R5"); put_sym(FILL, 1, 0, "R5");
      put_sym(K7P, 1, 0, "R5"); put_sym(FILL, 1, 0, "R5");
      // R4: enable high follows each new comma start
      put_pad(2, 1, 1, "R4"); put_sym(K5N, 1, 1, "R4"); put_sym(FILL, 1, 1, "R4");
      put_pad(5, 1, 1, "R4"); put_sym(K7N, 1, 1, "R4"); put_sym(FILL, 1, 1, "R4");
      // R3: every comma variant on the boundary
      put_sym(K1P, 1, 1, "R3"); put_sym(FILL, 1, 1, "R3"); put_sym(K5P, 1, 1, "R3");
      put_sym(10'h0F3, 1, 1, "R3"); put_sym(K7N, 1, 1, "R3"); put_sym(FILL, 1, 1, "R3");
      put_sym(K1N, 1, 1, "R3"); put_sym(K7P, 1, 1, "R3");
      // R2: plain data words, bit order and spacing
      put_sym(10'h1A5, 1, 1, "R2"); put_sym(10'h26D, 1, 1, "R2");
      put_sym(10'h0CC, 1, 1, "R2"); put_sym(10'h333, 1, 1, "R2");

      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (word_vld_o !== 1'b0 || comma_o !== 1'b0 || word_o !== '0) begin
         fails++;
         $display("FAIL R1 reset actual=%h/%b/%b expected=000/0/0", word_o, word_vld_o, comma_o);
      end
      rst_n = 1'b1;
      drive_one(stim.pop_front());
      while (stim.size() > 0) begin
         @(negedge clk);
         drive_one(stim.pop_front());
      end
      for (int i = 0; i < 3 * W; i++) begin
         @(negedge clk);
         drive_one('{1'b0, lock_i, align_en_i, "R2"});
      end
      repeat (3) @(negedge clk);
      checks++;
      if (expq.size() != 0) begin
         fails++;
         $display("FAIL R2 words missing actual=%0d expected=0", expq.size());
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule